// File: doc/BRIEF.md
# Audio Effect DSP Multiply-Accumulate Step

This block is the arithmetic stage of one microprogram step in an audio effect processor. From the decoded control bits of the current step it chooses three operands: a multiplicand X, a multiplier Y and an addend B. It multiplies X by Y at full signed width, scales the product by an arithmetic right shift of 12 and adds B. The sum is stored in a wrapping signed accumulator.

X is either the word from the input source selector or the word read from a 128-entry temporary RAM. B is either the temporary RAM word or the accumulator left by the previous step, and it can be negated or forced to zero. Y is the fraction register, a scaled coefficient word, or one of two slices of a Y latch. The temporary RAM is addressed as a ring: the step's offset field is added to a base counter supplied from outside, modulo the RAM depth.

The accumulator advances only on a step strobe. Operand selection is purely combinational, so a result written in one step is what a later step reads back as B. Instruction fetch, the external memory interface and the output shifter lie outside this block.

Top module: `adsp_mac_step`

## Requirements
- R1: `temp_addr` equals (`tra` + `ring_ofs`) modulo 128 at all times, so an offset past the top wraps to the bottom of the ring.
- R2: With `xsel`=1, X is the input source word. With `xsel`=0, X is `temp_rdata`. Both are treated as 24-bit signed.
- R3: B is the accumulator when `bsel`=1 and sign-extended `temp_rdata` when `bsel`=0. `negb`=1 negates it (two's complement). `zero`=1 forces B to 0 and takes priority over `negb`.
- R4: `ysel` picks Y as follows. 0 gives `frc` as 13-bit signed. 1 gives `coef` as 16-bit signed, arithmetically shifted right by 3. 2 gives `yreg` as 24-bit signed, arithmetically shifted right by 11. 3 gives `yreg[15:4]` as a 12-bit unsigned value.
- R5: On a clock edge with `step_valid`=1, `acc` takes the value ((X*Y) >>> 12) + B, where the product is exact and signed. Only the low 26 bits of the sum are kept, so overflow wraps.
- R6: On a clock edge with `step_valid`=0, `acc` keeps its value.
- R7: While `rst_n` is low, `acc` is 0 (asynchronous, active-low reset).
- R8: The input source word depends on `ira`. Values 0x00–0x1F select `mems_rdata`, with `mems_idx` = `ira[4:0]`. Values 0x20–0x37 select `ext_rdata`, with `ext_idx` = `ira` − 0x20. Values 0x38–0x3F give 0.
- R9: The accumulator written by one step is the value seen as B (`bsel`=1) by the next step, never the same step's sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | Advances the accumulator by one step |
| xsel | input | 1 | X source: 1 input word, 0 temporary RAM |
| bsel | input | 1 | B source: 1 accumulator, 0 temporary RAM |
| negb | input | 1 | Negate B |
| zero | input | 1 | Force B to zero |
| ysel | input | 2 | Y source select |
| ira | input | 6 | Input source index |
| mems_idx | output | 5 | Index into the sample register file |
| mems_rdata | input | 24 | Sample register read data |
| ext_idx | output | 5 | Index into the auxiliary input sources |
| ext_rdata | input | 24 | Auxiliary input read data |
| tra | input | 7 | Temporary RAM offset for this step |
| ring_ofs | input | 7 | Ring base counter |
| temp_addr | output | 7 | Temporary RAM read address |
| temp_rdata | input | 24 | Temporary RAM read data |
| frc | input | 13 | Fraction register |
| coef | input | 16 | Coefficient word |
| yreg | input | 24 | Y latch |
| acc | output | 26 | Accumulator |

## Verification
On every cycle, the assertions check that the accumulator holds without a strobe. They also check three cases where the product is known to be zero: it is exactly zero when B is cleared, it repeats the prior step's value when B is fed back, and it is the negated prior value when B is fed back and negated. During reset they check that the accumulator is cleared. The exact scaling, the Y slicing rules, wrap-around on overflow and the input index decoding can only be shown by the bench. It compares every step against a reference model, using random operands together with directed cases at the index and ring boundaries and a run of fed-back additions that overflows.

// File: rtl/adsp_mac_pkg.sv
package adsp_mac_pkg;
   typedef enum logic [1:0] {
      Y_FRC  = 2'd0,
      Y_COEF = 2'd1,
      Y_YHI  = 2'd2,
      Y_YMID = 2'd3
   } ysel_e;

   localparam int COEF_SHR    = 3;
   localparam int YHI_SHR     = 11;
   localparam int YMID_LO     = 4;
   localparam int YMID_W      = 12;
   localparam int SRC_MEMS_N  = 32;
   localparam int SRC_LIMIT   = 56;
endpackage

// File: rtl/mac_in_sel.sv
module mac_in_sel #(
   parameter int DW         = 24,
   parameter int IW         = 6,
   parameter bit EXT_SRC_EN = 1'b1
) (
   input  logic [IW-1:0] ira,
   input  logic [DW-1:0] mems_rdata,
   input  logic [DW-1:0] ext_rdata,
   output logic [4:0]    mems_idx,
   output logic [4:0]    ext_idx,
   output logic [DW-1:0] in_word
);
   import adsp_mac_pkg::*;

   if (IW < 6) begin : g_iw_chk
      $error("mac_in_sel: IW must be at least 6");
   end

   assign mems_idx = ira[4:0];
   assign ext_idx  = 5'(ira - IW'(SRC_MEMS_N));

   if (EXT_SRC_EN) begin : g_ext
      always_comb begin
         if (int'(ira) < SRC_MEMS_N)     in_word = mems_rdata;
         else if (int'(ira) < SRC_LIMIT) in_word = ext_rdata;
         else                            in_word = '0;
      end
   end else begin : g_noext
      always_comb begin
         if (int'(ira) < SRC_MEMS_N) in_word = mems_rdata;
         else                        in_word = '0;
      end
   end
endmodule

// File: rtl/mac_xb_sel.sv
module mac_xb_sel #(
   parameter int DW   = 24,
   parameter int AW   = 7,
   parameter int ACCW = 26
) (
   input  logic                   xsel,
   input  logic                   bsel,
   input  logic                   negb,
   input  logic                   zero,
   input  logic [AW-1:0]          tra,
   input  logic [AW-1:0]          ring_ofs,
   input  logic [DW-1:0]          temp_rdata,
   input  logic [DW-1:0]          in_word,
   input  logic [ACCW-1:0]        acc,
   output logic [AW-1:0]          temp_addr,
   output logic signed [DW-1:0]   x_op,
   output logic signed [ACCW-1:0] b_op
);
   logic signed [ACCW-1:0] b_raw;

   if (ACCW < DW) begin : g_w_chk
      $error("mac_xb_sel: ACCW must not be narrower than DW");
   end

   assign temp_addr = tra + ring_ofs;
   assign x_op      = xsel ? $signed(in_word) : $signed(temp_rdata);

   always_comb begin
      b_raw = bsel ? $signed(acc) : ACCW'($signed(temp_rdata));
      if (zero)      b_op = '0;
      else if (negb) b_op = -b_raw;
      else           b_op = b_raw;
   end
endmodule

// File: rtl/mac_y_sel.sv
module mac_y_sel #(
   parameter int FW  = 13,
   parameter int CW  = 16,
   parameter int YLW = 24,
   parameter int YW  = 14
) (
   input  logic [1:0]           ysel,
   input  logic [FW-1:0]        frc,
   input  logic [CW-1:0]        coef,
   input  logic [YLW-1:0]       yreg,
   output logic signed [YW-1:0] y_op
);
   import adsp_mac_pkg::*;

   logic signed [CW-1:0]  coef_sh;
   logic signed [YLW-1:0] yhi_sh;

   if (YW < CW - COEF_SHR || YW < YLW - YHI_SHR || YW <= YMID_W || YW < FW)
   begin : g_w_chk
      $error("mac_y_sel: YW too narrow for a Y source");
   end

   assign coef_sh = $signed(coef) >>> COEF_SHR;
   assign yhi_sh  = $signed(yreg) >>> YHI_SHR;

   always_comb begin
      case (ysel_e'(ysel))
         Y_FRC:   y_op = YW'($signed(frc));
         Y_COEF:  y_op = YW'(coef_sh);
         Y_YHI:   y_op = YW'(yhi_sh);
         default: y_op = YW'(yreg[YMID_LO +: YMID_W]);
      endcase
   end
endmodule

// File: rtl/mac_acc_core.sv
module mac_acc_core #(
   parameter int DW     = 24,
   parameter int YW     = 14,
   parameter int ACCW   = 26,
   parameter int PSHIFT = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   step_valid,
   input  logic signed [DW-1:0]   x_op,
   input  logic signed [YW-1:0]   y_op,
   input  logic signed [ACCW-1:0] b_op,
   output logic [ACCW-1:0]        acc
);
   localparam int PW = DW + YW;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] scaled;
   logic [ACCW-1:0]      acc_nxt;

   if (PW - PSHIFT < ACCW) begin : g_w_chk
      $error("mac_acc_core: scaled product narrower than accumulator");
   end

   assign prod    = PW'(x_op) * PW'(y_op);
   assign scaled  = prod >>> PSHIFT;
   assign acc_nxt = scaled[ACCW-1:0] + b_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc <= '0;
      else if (step_valid) acc <= acc_nxt;
   end
endmodule

// File: rtl/adsp_mac_step.sv
module adsp_mac_step #(
   parameter int DW         = 24,
   parameter int AW         = 7,
   parameter int FW         = 13,
   parameter int CW         = 16,
   parameter int YLW        = 24,
   parameter int ACCW       = 26,
   parameter int PSHIFT     = 12,
   parameter bit EXT_SRC_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_valid,
   input  logic            xsel,
   input  logic            bsel,
   input  logic            negb,
   input  logic            zero,
   input  logic [1:0]      ysel,
   input  logic [5:0]      ira,
   output logic [4:0]      mems_idx,
   input  logic [DW-1:0]   mems_rdata,
   output logic [4:0]      ext_idx,
   input  logic [DW-1:0]   ext_rdata,
   input  logic [AW-1:0]   tra,
   input  logic [AW-1:0]   ring_ofs,
   output logic [AW-1:0]   temp_addr,
   input  logic [DW-1:0]   temp_rdata,
   input  logic [FW-1:0]   frc,
   input  logic [CW-1:0]   coef,
   input  logic [YLW-1:0]  yreg,
   output logic [ACCW-1:0] acc
);
   localparam int YW = FW + 1;

   logic [DW-1:0]          in_word;
   logic signed [DW-1:0]   x_op;
   logic signed [YW-1:0]   y_op;
   logic signed [ACCW-1:0] b_op;

   mac_in_sel #(.DW(DW), .IW(6), .EXT_SRC_EN(EXT_SRC_EN)) in_sel_i (
      .ira(ira), .mems_rdata(mems_rdata), .ext_rdata(ext_rdata),
      .mems_idx(mems_idx), .ext_idx(ext_idx), .in_word(in_word)
   );

   mac_xb_sel #(.DW(DW), .AW(AW), .ACCW(ACCW)) xb_sel_i (
      .xsel(xsel), .bsel(bsel), .negb(negb), .zero(zero),
      .tra(tra), .ring_ofs(ring_ofs), .temp_rdata(temp_rdata),
      .in_word(in_word), .acc(acc), .temp_addr(temp_addr),
      .x_op(x_op), .b_op(b_op)
   );

   mac_y_sel #(.FW(FW), .CW(CW), .YLW(YLW), .YW(YW)) y_sel_i (
      .ysel(ysel), .frc(frc), .coef(coef), .yreg(yreg), .y_op(y_op)
   );

   mac_acc_core #(.DW(DW), .YW(YW), .ACCW(ACCW), .PSHIFT(PSHIFT)) core_i (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
      .x_op(x_op), .y_op(y_op), .b_op(b_op), .acc(acc)
   );
endmodule

// File: rtl/adsp_mac_chk.sv
module adsp_mac_chk #(
   parameter int FW   = 13,
   parameter int YLW  = 24,
   parameter int ACCW = 26
) (
   input logic            clk,
   input logic            rst_n,
   input logic            step_valid,
   input logic            bsel,
   input logic            negb,
   input logic            zero,
   input logic [1:0]      ysel,
   input logic [FW-1:0]   frc,
   input logic [YLW-1:0]  yreg,
   input logic [ACCW-1:0] acc
);
   logic y_is_zero;
   assign y_is_zero = (ysel == 2'd3 && yreg[15:4] == '0) || (ysel == 2'd0 && frc == '0);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !step_valid |=> $stable(acc));

   p_zero_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid && zero && y_is_zero |=> acc == '0);

   p_feedback_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid && bsel && !zero && !negb && y_is_zero |=> acc == $past(acc));

   p_negate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid && bsel && !zero && negb && y_is_zero |=> acc == ACCW'(-$past(acc)));

   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_r7: assert (acc == '0);
      end
   end
endmodule

bind adsp_mac_step adsp_mac_chk #(.FW(FW), .YLW(YLW), .ACCW(ACCW)) chk_i (
   .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .bsel(bsel),
   .negb(negb), .zero(zero), .ysel(ysel), .frc(frc), .yreg(yreg), .acc(acc)
);

// File: tb/adsp_mac_step_tb_top.sv
module adsp_mac_step_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        step_valid, xsel, bsel, negb, zero;
   logic [1:0]  ysel;
   logic [5:0]  ira;
   logic [4:0]  mems_idx, ext_idx;
   logic [23:0] mems_rdata, ext_rdata, temp_rdata, yreg;
   logic [6:0]  tra, ring_ofs, temp_addr;
   logic [12:0] frc;
   logic [15:0] coef;
   logic [25:0] acc;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [25:0] m_acc = '0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   adsp_mac_step dut_i (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .xsel(xsel),
      .bsel(bsel), .negb(negb), .zero(zero), .ysel(ysel), .ira(ira),
      .mems_idx(mems_idx), .mems_rdata(mems_rdata), .ext_idx(ext_idx),
      .ext_rdata(ext_rdata), .tra(tra), .ring_ofs(ring_ofs),
      .temp_addr(temp_addr), .temp_rdata(temp_rdata), .frc(frc),
      .coef(coef), .yreg(yreg), .acc(acc)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic longint sx(input logic [63:0] v, input int w);
      longint t;
      t = longint'(v << (64 - w));
      return t >>> (64 - w);
   endfunction

   function automatic logic [25:0] f_next();
      longint inw, xv, yv, bv, pr;
      if (ira < 6'd32)      inw = sx(64'(mems_rdata), 24);
      else if (ira < 6'd56) inw = sx(64'(ext_rdata), 24);
      else                  inw = 0;
      xv = xsel ? inw : sx(64'(temp_rdata), 24);
      case (ysel)
         2'd0:    yv = sx(64'(frc), 13);
         2'd1:    yv = sx(64'(coef), 16) >>> 3;
         2'd2:    yv = sx(64'(yreg), 24) >>> 11;
         default: yv = longint'(yreg[15:4]);
      endcase
      pr = (xv * yv) >>> 12;
      bv = bsel ? sx(64'(m_acc), 26) : sx(64'(temp_rdata), 24);
      if (negb) bv = -bv;
      if (zero) bv = 0;
      return 26'(pr + bv);
   endfunction

   task automatic set_rand();
      step_valid = ($urandom % 8) != 0;
      xsel = 1'($urandom); bsel = 1'($urandom);
      negb = 1'($urandom); zero = ($urandom % 4) == 0;
      ysel = 2'($urandom); ira = 6'($urandom);
      mems_rdata = 24'($urandom); ext_rdata = 24'($urandom);
      temp_rdata = 24'($urandom); yreg = 24'($urandom);
      tra = 7'($urandom); ring_ofs = 7'($urandom);
      frc = 13'($urandom); coef = 16'($urandom);
   endtask

   task automatic set_plain();
      step_valid = 1'b1; xsel = 1'b1; bsel = 1'b0; negb = 1'b0; zero = 1'b1;
      ysel = 2'd1; coef = 16'h7FFF; ira = 6'd0;
   endtask

   task automatic do_step(input string tag);
      logic [25:0] nxt;
      logic [6:0]  ea;
      #1;
      ea = tra + ring_ofs;
      chk(temp_addr == ea, "R1 temp_addr", temp_addr, ea);
      if (ira < 6'd32)
         chk(mems_idx == ira[4:0], "R8 mems_idx", mems_idx, ira[4:0]);
      else if (ira < 6'd56)
         chk(ext_idx == 5'(ira - 6'd32), "R8 ext_idx", ext_idx, 5'(ira - 6'd32));
      nxt = step_valid ? f_next() : m_acc;
      @(negedge clk);
      chk(acc == nxt, step_valid ? tag : "R6 hold", acc, nxt);
      m_acc = nxt;
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0;
      set_rand();
      @(negedge clk);
      chk(acc == '0, "R7 reset", acc, 0);
      @(negedge clk);
      chk(acc == '0, "R7 reset held", acc, 0);
      rst_n = 1'b1;

      tra = 7'h7F; ring_ofs = 7'h05; step_valid = 1'b0;
      do_step("R1 ring wrap");

      set_plain();
      mems_rdata = 24'h123456; ext_rdata = 24'hABCDEF; temp_rdata = 24'h0F0F0F;
      foreach (ira_list[i]) begin
         ira = ira_list[i];
         do_step("R8 input source");
      end

      set_plain(); xsel = 1'b0; temp_rdata = 24'h800001; mems_rdata = 24'h000100;
      do_step("R2 x from temp");
      xsel = 1'b1;
      do_step("R2 x from input");

      set_plain(); yreg = 24'hFFFFFF; frc = 13'h1000; coef = 16'h8000;
      mems_rdata = 24'h7FFFFF;
      for (int s = 0; s < 4; s++) begin
         ysel = 2'(s);
         do_step("R4 y select");
      end

      set_plain(); mems_rdata = 24'h7FFFFF;
      do_step("R5 load large");
      zero = 1'b0; bsel = 1'b1;
      for (int k = 0; k < 8; k++) do_step("R9 feedback wrap R5");

      negb = 1'b1; ysel = 2'd3; yreg = '0;
      do_step("R3 negate acc");
      bsel = 1'b0; temp_rdata = 24'h800000;
      do_step("R3 negate temp");
      zero = 1'b1;
      do_step("R3 zero over negb");

      step_valid = 1'b0; ysel = 2'd1;
      do_step("R6 hold");

      for (int n = 0; n < 600; n++) begin
         set_rand();
         do_step("R5 random");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   logic [5:0] ira_list [6] = '{6'h00, 6'h1F, 6'h20, 6'h37, 6'h38, 6'h3F};

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule